// File: doc/BRIEF.md
# Down-Spread Frequency Modulation Generator

This block produces the frequency-control word for a numerically controlled oscillator or a fractional synthesizer. When spread is enabled, it sweeps that word below a nominal value along a triangular profile. This spreads the emitted clock energy over a narrow band and lowers the peak radiated emission. The word never rises above nominal. The sweep depth is either 1.0% or 0.5% of nominal, selected by one input bit.

Enable comes from one of two sources, chosen by a source-select input. In hardware mode an active-low pin enables spread. In register mode a control bit enables it. A programmable step period sets how often the profile moves. The per-step increment is derived from the depth, so that each half of the triangle covers the full depth exactly. An output flag reports whether modulation is currently applied.

Top module: `dss_downspread_gen`

## Requirements
- R1: `freq_word` is never greater than `nominal_word`.
- R2: The depth is floor(`nominal_word`/100) when `narrow_sel` is 0 and floor(`nominal_word`/200) when it is 1. While spread is active, `nominal_word - freq_word` never exceeds that depth. The bottom of each sweep reaches exactly `nominal_word - depth`.
- R3: When `src_hw` is 1, spread is enabled exactly when `spread_pin_n` is 0. In this mode `reg_spread_on` has no effect.
- R4: When `src_hw` is 0, spread is enabled exactly when `reg_spread_on` is 1. In this mode `spread_pin_n` has no effect.
- R5: The profile moves only on step ticks. A step counter cleared by reset raises a tick whenever it is at or above `step_period` and then restarts at 0, so ticks come every `step_period`+1 cycles. Between ticks, `freq_word` (for a fixed nominal) and `spread_active` hold.
- R6: The increment is max(depth >> 4, 1). From nominal, each tick lowers the word by the increment until the offset would reach the depth. The offset is then clamped to the depth and the direction turns upward. Each further tick raises the word by the increment, clamped at nominal, after which the descent starts again.
- R7: At the first tick after spread becomes disabled, `freq_word` equals `nominal_word` and `spread_active` is 0. The next enabled sweep starts downward from nominal. `spread_active` becomes 1 at the first tick at which spread is enabled.
- R8: A change of `narrow_sel` during a sweep takes effect only when the word has returned to nominal and a new descent begins.
- R9: After reset, `freq_word` equals `nominal_word` and `spread_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spread_pin_n | input | 1 | Active-low spread enable pin (hardware mode) |
| src_hw | input | 1 | 1: enable taken from pin, 0: from register bit |
| reg_spread_on | input | 1 | Register spread enable (register mode) |
| narrow_sel | input | 1 | 0: 1.0% depth, 1: 0.5% depth |
| nominal_word | input | WORD_W | Unmodulated frequency word |
| step_period | input | PER_W | Profile step period minus one, in cycles |
| freq_word | output | WORD_W | Modulated frequency word |
| spread_active | output | 1 | Modulation currently applied |

## Verification
The depth-bound property assumes that `nominal_word` is held constant while modulation is active. The depth and increment latched at the start of a sweep belong to the nominal value of that moment. The stimulus therefore changes the nominal word only after a disable has taken effect and the flag has dropped. The stimulus toggles `narrow_sel`, the source select and the period freely in mid-sweep, because the design must absorb those changes.

// File: rtl/dss_pkg.sv
package dss_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // divisors giving the two depths from the nominal word
    localparam int unsigned WIDE_DIV   = 100;
    localparam int unsigned NARROW_DIV = 200;

    typedef enum logic {
        SWEEP_DOWN = 1'b0,
        SWEEP_UP   = 1'b1
    } sweep_dir_e;

    typedef struct packed {
        sweep_dir_e dir;
        logic       active;
    } sweep_ctl_t;

    function automatic logic resolve_enable(input logic hw_sel,
                                            input logic pin_n,
                                            input logic reg_on);
        return hw_sel ? ~pin_n : reg_on;
    endfunction
endpackage

// File: rtl/dss_step_timer.sv
module dss_step_timer #(
    parameter int unsigned PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [PER_W-1:0] cnt_q;

    assign tick = (cnt_q >= period);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dss_depth_calc.sv
module dss_depth_calc #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned HALF_LOG2 = 4
) (
    input  logic [WORD_W-1:0] nominal,
    input  logic              narrow,
    output logic [WORD_W-1:0] depth,
    output logic [WORD_W-1:0] incr
);
    timeunit 1ns;
    timeprecision 1ps;
    import dss_pkg::*;

    localparam logic [WORD_W-1:0] DIV_WIDE   = WORD_W'(WIDE_DIV);
    localparam logic [WORD_W-1:0] DIV_NARROW = WORD_W'(NARROW_DIV);
    localparam logic [WORD_W-1:0] ONE        = WORD_W'(1);

    logic [WORD_W-1:0] raw_step;

    assign depth = narrow ? (nominal / DIV_NARROW) : (nominal / DIV_WIDE);

    generate
        if (HALF_LOG2 == 0) begin : g_single
            assign raw_step = depth;
        end else begin : g_shift
            assign raw_step = depth >> HALF_LOG2;
        end
    endgenerate

    assign incr = (raw_step == '0) ? ONE : raw_step;
endmodule

// File: rtl/dss_profile.sv
module dss_profile #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              enable,
    input  logic [WORD_W-1:0] live_depth,
    input  logic [WORD_W-1:0] live_incr,
    output logic [WORD_W-1:0] offset,
    output logic              active
);
    timeunit 1ns;
    timeprecision 1ps;
    import dss_pkg::*;

    logic [WORD_W-1:0] off_q, off_d;
    logic [WORD_W-1:0] depth_q, incr_q;
    logic [WORD_W-1:0] eff_depth, eff_incr;
    logic [WORD_W:0]   down_sum;
    sweep_ctl_t        ctl_q, ctl_d;
    logic              at_top;

    // the depth is re-read only when a fresh descent starts at nominal
    assign at_top    = (off_q == '0) && (ctl_q.dir == SWEEP_DOWN);
    assign eff_depth = at_top ? live_depth : depth_q;
    assign eff_incr  = at_top ? live_incr  : incr_q;
    assign down_sum  = {1'b0, off_q} + {1'b0, eff_incr};

    always_comb begin
        off_d = off_q;
        ctl_d = ctl_q;
        if (!enable) begin
            off_d        = '0;
            ctl_d.dir    = SWEEP_DOWN;
            ctl_d.active = 1'b0;
        end else begin
            ctl_d.active = 1'b1;
            if (ctl_q.dir == SWEEP_DOWN) begin
                if (down_sum >= {1'b0, eff_depth}) begin
                    off_d     = eff_depth;
                    ctl_d.dir = SWEEP_UP;
                end else begin
                    off_d = down_sum[WORD_W-1:0];
                end
            end else begin
                if (off_q <= eff_incr) begin
                    off_d     = '0;
                    ctl_d.dir = SWEEP_DOWN;
                end else begin
                    off_d = off_q - eff_incr;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q   <= '0;
            depth_q <= '0;
            incr_q  <= '0;
            ctl_q   <= '{dir: SWEEP_DOWN, active: 1'b0};
        end else if (tick) begin
            off_q   <= off_d;
            depth_q <= eff_depth;
            incr_q  <= eff_incr;
            ctl_q   <= ctl_d;
        end
    end

    assign offset = off_q;
    assign active = ctl_q.active;
endmodule

// File: rtl/dss_downspread_gen.sv
module dss_downspread_gen #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned PER_W     = 16,
    parameter int unsigned HALF_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spread_pin_n,
    input  logic              src_hw,
    input  logic              reg_spread_on,
    input  logic              narrow_sel,
    input  logic [WORD_W-1:0] nominal_word,
    input  logic [PER_W-1:0]  step_period,
    output logic [WORD_W-1:0] freq_word,
    output logic              spread_active
);
    timeunit 1ns;
    timeprecision 1ps;
    import dss_pkg::*;

    logic              step_tick;
    logic              spread_en;
    logic [WORD_W-1:0] live_depth, live_incr;
    logic [WORD_W-1:0] sweep_offset;

    assign spread_en = resolve_enable(src_hw, spread_pin_n, reg_spread_on);

    dss_step_timer #(.PER_W(PER_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .period (step_period),
        .tick   (step_tick)
    );

    dss_depth_calc #(.WORD_W(WORD_W), .HALF_LOG2(HALF_LOG2)) u_depth (
        .nominal (nominal_word),
        .narrow  (narrow_sel),
        .depth   (live_depth),
        .incr    (live_incr)
    );

    dss_profile #(.WORD_W(WORD_W)) u_prof (
        .clk        (clk),
        .rst        (rst),
        .tick       (step_tick),
        .enable     (spread_en),
        .live_depth (live_depth),
        .live_incr  (live_incr),
        .offset     (sweep_offset),
        .active     (spread_active)
    );

    assign freq_word = nominal_word - sweep_offset;
endmodule

// File: rtl/dss_downspread_chk.sv
module dss_downspread_chk #(
    parameter int unsigned WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              spread_pin_n,
    input logic              src_hw,
    input logic              reg_spread_on,
    input logic [WORD_W-1:0] nominal_word,
    input logic [WORD_W-1:0] freq_word,
    input logic              spread_active,
    input logic              step_tick,
    input logic [WORD_W-1:0] sweep_offset
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [WORD_W-1:0] WIDE = WORD_W'(100);

    p_never_above_r1: assert property (@(posedge clk) disable iff (rst)
        freq_word <= nominal_word);

    p_depth_bound_r2: assert property (@(posedge clk) disable iff (rst)
        spread_active |-> ((nominal_word - freq_word) <= (nominal_word / WIDE)));

    p_pin_off_r3: assert property (@(posedge clk) disable iff (rst)
        (step_tick && src_hw && spread_pin_n) |=> (!spread_active && freq_word == nominal_word));

    p_reg_on_r4: assert property (@(posedge clk) disable iff (rst)
        (step_tick && !src_hw && reg_spread_on) |=> spread_active);

    p_hold_between_ticks_r5: assert property (@(posedge clk) disable iff (rst)
        !step_tick |=> ($stable(sweep_offset) && $stable(spread_active)));

    p_idle_nominal_r7: assert property (@(posedge clk) disable iff (rst)
        !spread_active |-> freq_word == nominal_word);
endmodule

bind dss_downspread_gen dss_downspread_chk #(.WORD_W(WORD_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .spread_pin_n  (spread_pin_n),
    .src_hw        (src_hw),
    .reg_spread_on (reg_spread_on),
    .nominal_word  (nominal_word),
    .freq_word     (freq_word),
    .spread_active (spread_active),
    .step_tick     (step_tick),
    .sweep_offset  (sweep_offset)
);

// File: tb/dss_downspread_gen_test.sv
module dss_downspread_gen_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spread_pin_n = 1'b1;
    logic        src_hw = 1'b1;
    logic        reg_spread_on = 1'b0;
    logic        narrow_sel = 1'b0;
    logic [31:0] nominal_word = 32'd100_000_000;
    logic [15:0] step_period = 16'd3;
    logic [31:0] freq_word;
    logic        spread_active;

    int    n_tests = 0;
    int    n_fail  = 0;
    string tag = "R9";
    longint min_seen, max_seen;

    // behavioural reference state
    longint m_cnt, m_off, m_dq, m_iq;
    bit     m_down, m_act;

    always #2 clk = ~clk;

    dss_downspread_gen uut (
        .clk           (clk),
        .rst           (rst),
        .spread_pin_n  (spread_pin_n),
        .src_hw        (src_hw),
        .reg_spread_on (reg_spread_on),
        .narrow_sel    (narrow_sel),
        .nominal_word  (nominal_word),
        .step_period   (step_period),
        .freq_word     (freq_word),
        .spread_active (spread_active)
    );

    always @(posedge clk) begin
        longint d, inc;
        bit en, top;
        if (rst) begin
            m_cnt = 0; m_off = 0; m_dq = 0; m_iq = 0; m_down = 1; m_act = 0;
        end else if (m_cnt >= longint'(step_period)) begin
            m_cnt = 0;
            en  = src_hw ? !spread_pin_n : reg_spread_on;
            top = (m_off == 0) && m_down;
            if (top) begin
                d   = narrow_sel ? longint'(nominal_word) / 200 : longint'(nominal_word) / 100;
                inc = d / 16;
                if (inc == 0) inc = 1;
            end else begin
                d = m_dq; inc = m_iq;
            end
            m_dq = d; m_iq = inc;
            if (!en) begin
                m_off = 0; m_down = 1; m_act = 0;
            end else begin
                m_act = 1;
                if (m_down) begin
                    if (m_off + inc >= d) begin m_off = d; m_down = 0; end
                    else m_off = m_off + inc;
                end else begin
                    if (m_off <= inc) begin m_off = 0; m_down = 1; end
                    else m_off = m_off - inc;
                end
            end
        end else begin
            m_cnt = m_cnt + 1;
        end
    end

    task automatic chk(string req, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step_cmp();
        longint exp_f;
        @(negedge clk);
        exp_f = longint'(nominal_word) - m_off;
        n_tests++;
        if (longint'(freq_word) != exp_f || spread_active !== m_act) begin
            n_fail++;
            $display("FAIL %s: freq %0d act %0b expected %0d act %0b",
                     tag, freq_word, spread_active, exp_f, m_act);
        end
        if (longint'(freq_word) < min_seen) min_seen = longint'(freq_word);
        if (longint'(freq_word) > max_seen) max_seen = longint'(freq_word);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step_cmp();
    endtask

    task automatic clear_range();
        min_seen = 64'sh7fff_ffff_ffff_ffff;
        max_seen = 0;
    endtask

    initial begin
        clear_range();
        run(3);
        rst = 1'b0;
        // R9: reset state
        chk("R9", longint'(freq_word), 100_000_000);
        chk("R9", longint'(spread_active), 0);
        tag = "R3"; run(40);                   // pin high in hardware mode: idle
        chk("R3", longint'(spread_active), 0);
        reg_spread_on = 1'b1; run(20);          // register bit ignored in hardware mode
        chk("R3", longint'(spread_active), 0);
        reg_spread_on = 1'b0;
        spread_pin_n = 1'b0; tag = "R6"; clear_range(); run(300);
        chk("R2", min_seen, 99_000_000);
        chk("R1", max_seen <= 100_000_000 ? 1 : 0, 1);
        chk("R3", longint'(spread_active), 1);
        narrow_sel = 1'b1; tag = "R8"; run(200);
        spread_pin_n = 1'b1; tag = "R7"; run(5);
        chk("R7", longint'(freq_word), 100_000_000);
        chk("R7", longint'(spread_active), 0);
        src_hw = 1'b0; spread_pin_n = 1'b0; tag = "R4"; run(20);
        chk("R4", longint'(spread_active), 0); // pin ignored in register mode
        reg_spread_on = 1'b1; run(150);
        chk("R4", longint'(spread_active), 1);
        reg_spread_on = 1'b0; tag = "R7"; run(8);
        chk("R7", longint'(freq_word), 100_000_000);
        nominal_word = 32'd33_333_333; narrow_sel = 1'b1; step_period = 16'd0;
        reg_spread_on = 1'b1; tag = "R5"; clear_range(); run(120);
        chk("R2", min_seen, 33_333_333 - 166_666);
        step_period = 16'd10; run(400);
        narrow_sel = 1'b0; tag = "R8"; clear_range(); run(1200);
        chk("R8", min_seen, 33_333_333 - 333_333);
        chk("R1", max_seen <= 33_333_333 ? 1 : 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule